// File: doc/BRIEF.md
# Graceful Reset-Button Controller

This block turns a noisy, active-low reset-button input into one clean system reset request of fixed width. The button level is first brought into the clock domain through a short flop chain. It is then debounced, so that a press or a release only counts once the new level has held for a set number of timebase ticks.

When a press is qualified, the controller tries to reset gracefully. If the side-band management bus already reports idle, the request is raised at once. If the bus is busy, the controller waits a bounded number of ticks for idle. It raises the request on the first cycle idle is seen. If the wait runs out first, it raises the request anyway. The request then holds for a fixed number of ticks, whatever the button does. The controller re-arms only once three conditions hold together: the debounced button is released, the system reports full-on, and platform reset is inactive.

All durations are parameters counted in ticks of an external timebase strobe (for example one tick per millisecond). A bench can therefore use short windows. The bus protocol itself lies outside this block; only its idle flag is used.

Top module: `graceful_reset_ctrl`

## Requirements
- R1: The button level passes a synchronizer of SYNC_STAGES flops. A change is accepted only after the synchronized level has differed from the accepted level on DEBOUNCE_TICKS consecutive ticks. A return to the accepted level restarts the count, so a shorter glitch produces no reset request.
- R2: If the bus idle flag is high in the cycle a press is accepted, rst_req_o goes high on the next clock edge.
- R3: If the bus is busy when the press is accepted, the block waits. It raises rst_req_o on the clock edge after the first cycle in which the bus idle flag is high during that wait.
- R4: If the bus stays busy for WAIT_TICKS ticks of waiting, rst_req_o is raised anyway, with the bus still busy.
- R5: Once raised, rst_req_o stays high for exactly PULSE_TICKS ticks, counting ticks in the cycles where it is high. The button level has no effect on this width.
- R6: After a request, no new request can start until the debounced button is released, sys_on_i is high and plat_rst_ni is high, all in the same cycle. A button held, or pressed again before these hold, produces no second request.
- R7: Asserting rst_ni low forces rst_req_o low at once and returns the block to its idle state. With the button released and no press, rst_req_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one cycle high per time unit |
| btn_ni | input | 1 | Reset button, active low, asynchronous |
| bus_idle_i | input | 1 | High while the management bus is idle |
| sys_on_i | input | 1 | High while the system is in its full-on state |
| plat_rst_ni | input | 1 | Platform reset, active low; high when inactive |
| rst_req_o | output | 1 | Reset request pulse, active high |

## Verification
The bench builds the block with a debounce window of 4 ticks, a bus-idle wait of 6 ticks and a pulse of 3 ticks, and it strobes the tick every fourth clock. With these values every window fits in a few dozen cycles. The forced timeout, the mid-wait idle exit, a glitch shorter than the debounce window and the re-arm hold all come within reach many times over in one short run. The windows are unequal on purpose, so that an immediate assertion (about 4 ticks after a press) and a forced one (about 10 ticks) fall in separate, non-overlapping tolerance ranges. For the same reason, a pulse that is one tick short or long is caught.

// File: rtl/rstbtn_pkg.sv
`timescale 1ns/1ps
package rstbtn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_IDLE = 2'd1,
    ST_ASSERT    = 2'd2,
    ST_REARM     = 2'd3
  } rb_state_e;

endpackage

// File: rtl/rstbtn_sync.sv
`timescale 1ns/1ps
module rstbtn_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstbtn_debounce.sv
`timescale 1ns/1ps
module rstbtn_debounce #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_n_i,
  output logic level_n_o
);

  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // a differing level must survive TICKS strobes in a row
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (raw_n_i == lvl_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        lvl_d = raw_n_i;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_n_o = lvl_q;

endmodule

// File: rtl/rstbtn_timer.sv
`timescale 1ns/1ps
module rstbtn_timer #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             done_o
);

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - WIDTH'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/graceful_reset_ctrl.sv
`timescale 1ns/1ps
module graceful_reset_ctrl
  import rstbtn_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 16,
  parameter int unsigned WAIT_TICKS     = 25,
  parameter int unsigned PULSE_TICKS    = 1,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_ni,
  input  logic bus_idle_i,
  input  logic sys_on_i,
  input  logic plat_rst_ni,
  output logic rst_req_o
);

  localparam int unsigned TMR_MAX = (WAIT_TICKS > PULSE_TICKS) ? WAIT_TICKS : PULSE_TICKS;
  localparam int unsigned TW      = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] WAIT_LOAD  = TW'(WAIT_TICKS);
  localparam logic [TW-1:0] PULSE_LOAD = TW'(PULSE_TICKS);

  logic btn_sync_n;
  logic btn_db_n;
  logic tmr_load;
  logic [TW-1:0] tmr_val;
  logic tmr_done;
  logic rearm_ok;

  rb_state_e state_q, state_d;
  logic      req_q, req_d;

  rstbtn_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (btn_ni),
    .q_o    (btn_sync_n)
  );

  rstbtn_debounce #(
    .TICKS (DEBOUNCE_TICKS)
  ) u_debounce (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .raw_n_i   (btn_sync_n),
    .level_n_o (btn_db_n)
  );

  // one timer serves both the bus wait and the pulse width
  rstbtn_timer #(
    .WIDTH (TW)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  assign rearm_ok = btn_db_n && sys_on_i && plat_rst_ni;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (!btn_db_n) begin
          tmr_load = 1'b1;
          if (bus_idle_i) begin
            state_d = ST_ASSERT;
            tmr_val = PULSE_LOAD;
          end else begin
            state_d = ST_WAIT_IDLE;
            tmr_val = WAIT_LOAD;
          end
        end
      end
      ST_WAIT_IDLE: begin
        if (bus_idle_i || tmr_done) begin
          state_d  = ST_ASSERT;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LOAD;
        end
      end
      ST_ASSERT: begin
        if (tmr_done) begin
          state_d = ST_REARM;
        end
      end
      ST_REARM: begin
        if (rearm_ok) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb req_d = (state_d == ST_ASSERT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  assign rst_req_o = req_q;

endmodule

// File: rtl/rstbtn_chk.sv
`timescale 1ns/1ps
module rstbtn_chk
  import rstbtn_pkg::*;
#(
  parameter int unsigned WAIT_TICKS  = 25,
  parameter int unsigned PULSE_TICKS = 1
) (
  input logic      clk,
  input logic      rst_n,
  input logic      tick_i,
  input logic      bus_idle_i,
  input logic      sys_on_i,
  input logic      plat_rst_ni,
  input logic      btn_level_n,
  input rb_state_e state,
  input logic      rst_req_o
);

  int unsigned wait_cnt;
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= 0;
      hi_cnt   <= 0;
    end else begin
      if (state != ST_WAIT_IDLE) wait_cnt <= 0;
      else if (tick_i)          wait_cnt <= wait_cnt + 1;
      if (!rst_req_o)           hi_cnt <= 0;
      else if (tick_i)          hi_cnt <= hi_cnt + 1;
    end
  end

  p_idle_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !btn_level_n && bus_idle_i) |=> (state == ST_ASSERT && rst_req_o));

  p_wait_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_IDLE && bus_idle_i) |=> rst_req_o);

  p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WAIT_TICKS);

  p_width_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= PULSE_TICKS);

  p_width_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> hi_cnt == PULSE_TICKS);

  p_rearm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REARM && !(btn_level_n && sys_on_i && plat_rst_ni)) |=> (state == ST_REARM));

  p_out_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o == (state == ST_ASSERT));

endmodule

bind graceful_reset_ctrl rstbtn_chk #(
  .WAIT_TICKS  (WAIT_TICKS),
  .PULSE_TICKS (PULSE_TICKS)
) u_chk (
  .clk         (clk_i),
  .rst_n       (rst_ni),
  .tick_i      (tick_i),
  .bus_idle_i  (bus_idle_i),
  .sys_on_i    (sys_on_i),
  .plat_rst_ni (plat_rst_ni),
  .btn_level_n (btn_db_n),
  .state       (state_q),
  .rst_req_o   (rst_req_o)
);

// File: tb/graceful_reset_ctrl_bench.sv
`timescale 1ns/1ps
module graceful_reset_ctrl_bench;

  localparam int D = 4;
  localparam int W = 6;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic btn_n = 1'b1;
  logic bus_idle = 1'b1;
  logic sys_on = 1'b1;
  logic plat_rst_n = 1'b1;
  logic rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int tick_total = 0;
  int pulse_count = 0;
  int rise_tick = 0;
  int cur_hi = 0;
  int last_width = 0;
  logic prev_req = 1'b0;
  logic [1:0] tdiv = 2'd0;

  graceful_reset_ctrl #(
    .DEBOUNCE_TICKS (D),
    .WAIT_TICKS     (W),
    .PULSE_TICKS    (P),
    .SYNC_STAGES    (2)
  ) u_graceful_reset_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .btn_ni      (btn_n),
    .bus_idle_i  (bus_idle),
    .sys_on_i    (sys_on),
    .plat_rst_ni (plat_rst_n),
    .rst_req_o   (rst_req)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #2;
    tdiv = tdiv + 2'd1;
    tick = (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (tick) tick_total = tick_total + 1;
    if (rst_req && !prev_req) begin
      pulse_count = pulse_count + 1;
      rise_tick = tick_total;
      cur_hi = tick ? 1 : 0;
    end else if (rst_req && tick) begin
      cur_hi = cur_hi + 1;
    end
    if (!rst_req && prev_req) last_width = cur_hi;
    prev_req = rst_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic tk(input int n);
    repeat (n * 4) cyc();
  endtask

  task automatic press_rise(output bit seen, output int dt);
    int t0, pc;
    t0 = tick_total;
    pc = pulse_count;
    btn_n = 1'b0;
    for (int i = 0; i < (D + W + 8) * 4 && pulse_count == pc; i++) cyc();
    seen = (pulse_count != pc);
    dt = rise_tick - t0;
  endtask

  task automatic wait_fall();
    for (int i = 0; i < (P + 4) * 4 && rst_req; i++) cyc();
    cyc();
  endtask

  task automatic rearm();
    btn_n = 1'b1;
    tk(D + 2);
  endtask

  task automatic t_reset();
    chk(rst_req == 1'b0, "R7 reset value", int'(rst_req), 0);
    tk(3);
    chk(rst_req == 1'b0, "R7 quiet after reset", int'(rst_req), 0);
  endtask

  task automatic t_immediate();
    bit seen; int dt;
    bus_idle = 1'b1;
    press_rise(seen, dt);
    chk(seen, "R2 request raised", int'(seen), 1);
    chk(dt >= D && dt <= D + 2, "R2 delay ticks", dt, D);
    wait_fall();
    chk(last_width == P, "R5 width", last_width, P);
    rearm();
  endtask

  task automatic t_forced();
    bit seen; int dt;
    bus_idle = 1'b0;
    press_rise(seen, dt);
    chk(seen, "R4 forced request", int'(seen), 1);
    chk(dt >= D + W && dt <= D + W + 2, "R4 forced delay ticks", dt, D + W);
    wait_fall();
    chk(last_width == P, "R5 width forced", last_width, P);
    rearm();
    bus_idle = 1'b1;
  endtask

  task automatic t_midwait();
    bus_idle = 1'b0;
    btn_n = 1'b0;
    tk(D + 2);
    chk(rst_req == 1'b0, "R3 held while busy", int'(rst_req), 0);
    bus_idle = 1'b1;
    cyc();
    chk(rst_req == 1'b1, "R3 raised after idle", int'(rst_req), 1);
    wait_fall();
    rearm();
  endtask

  task automatic t_bounce();
    int pc;
    bus_idle = 1'b1;
    pc = pulse_count;
    btn_n = 1'b0;
    tk(D - 2);
    btn_n = 1'b1;
    cyc();
    btn_n = 1'b0;
    tk(D - 1);
    btn_n = 1'b1;
    tk(D + 4);
    chk(pulse_count == pc, "R1 glitch ignored", pulse_count - pc, 0);
    chk(rst_req == 1'b0, "R1 output low", int'(rst_req), 0);
  endtask

  task automatic t_hold();
    bit seen; int dt; int pc;
    press_rise(seen, dt);
    pc = pulse_count;
    wait_fall();
    chk(last_width == P, "R5 width while held", last_width, P);
    tk(D + W + 4);
    chk(pulse_count == pc, "R6 held button no repeat", pulse_count - pc, 0);
    rearm();
  endtask

  task automatic t_release_mid();
    bit seen; int dt;
    press_rise(seen, dt);
    btn_n = 1'b1;
    wait_fall();
    chk(last_width == P, "R5 width after early release", last_width, P);
    tk(D + 2);
  endtask

  task automatic t_gate(input bit use_sys);
    bit seen; int dt; int pc;
    if (use_sys) sys_on = 1'b0; else plat_rst_n = 1'b0;
    press_rise(seen, dt);
    chk(seen, "R6 first request", int'(seen), 1);
    wait_fall();
    btn_n = 1'b1;
    tk(D + 2);
    pc = pulse_count;
    btn_n = 1'b0;
    tk(D + 3);
    chk(pulse_count == pc, use_sys ? "R6 blocked by sys_on" : "R6 blocked by plat_rst",
        pulse_count - pc, 0);
    btn_n = 1'b1;
    tk(D + 2);
    sys_on = 1'b1;
    plat_rst_n = 1'b1;
    cyc();
    press_rise(seen, dt);
    chk(seen, "R6 rearmed request", int'(seen), 1);
    wait_fall();
    rearm();
  endtask

  task automatic t_async();
    bit seen; int dt;
    press_rise(seen, dt);
    btn_n = 1'b1;
    rst_n = 1'b0;
    #1;
    chk(rst_req == 1'b0, "R7 async clear", int'(rst_req), 0);
    cyc();
    rst_n = 1'b1;
    tk(D + 2);
    chk(rst_req == 1'b0, "R7 idle after reset", int'(rst_req), 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_immediate();
    t_forced();
    t_midwait();
    t_bounce();
    t_hold();
    t_release_mid();
    t_gate(1'b1);
    t_gate(1'b0);
    t_async();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule